// File: doc/BRIEF.md
# Two-Way Set-Associative Write-Back Cache

This block sits between a processor load/store port and a word-wide backing memory. Every line of the cache holds `WORDS` data words. The request address selects one set, and the set is the block number modulo `SETS`. Both ways of that set compare their stored tag against the request tag in the same cycle. A hit is served from the cache. A store hit changes only the cached copy and marks that line dirty, so memory receives the data later, when the line is evicted.

On a miss the block picks a victim way. An empty way is taken first. When both ways hold lines, the block takes the way that was used least recently, and one bit per set tracks this. If the victim is dirty, its words are written to memory one at a time in ascending offset order. The new line is then read word by word. Store misses also allocate: the line is fetched first and the store is applied to it afterwards. The processor is stalled from the moment the request is accepted until the response pulse.

Both request channels use a valid/ready handshake. A request transfers on a rising edge where valid and ready are both high. A master that raises valid keeps the payload steady until that transfer happens. The processor-side ready is high only when the block is idle. The memory side may hold ready low for as long as it wants, and the cache then keeps its request unchanged. The two response channels carry no ready signal. The processor must take `cpu_rsp_*` during the single cycle it is valid. Memory returns exactly one `mem_rsp_*` beat for each accepted read, and only one read is outstanding at any time. Constraints: `SETS` ≥ 2 and `WORDS` ≥ 2, both powers of two.

Top module: `cache2w`

## Requirements
- R1: Address fields: the word offset is the low `log2(WORDS)` bits, the set index is the next `log2(SETS)` bits, and the tag is the remaining high bits. Both ways are compared at once and at most one of them hits. A hit is answered with `cpu_rsp_hit`=1 and causes no memory request.
- R2: On a miss, a way with a clear valid bit is filled before any valid way is replaced. Two different blocks that miss into an empty set therefore both remain resident.
- R3: When both ways are valid, the miss replaces the way used least recently. Every hit and every fill records its way as most recently used.
- R4: A store hit writes only the cache and marks the line dirty. It produces no memory write.
- R5: A dirty victim is written back to memory as `WORDS` writes at the old line's addresses, in ascending offset order, with the line's current data. All of these writes complete before the first refill read is issued.
- R6: A clean or empty victim is replaced without any memory write.
- R7: A miss reads the new line as `WORDS` reads in ascending offset order. A store miss fetches the line first and then applies the store. The response to any request that missed carries `cpu_rsp_hit`=0.
- R8: `cpu_req_ready` is low from the cycle after a request is accepted until the response. `cpu_rsp_valid` is a pulse of exactly one cycle.
- R9: While `mem_req_valid` is high and `mem_req_ready` is low, the memory request (valid, write flag, address, write data) holds steady into the next cycle.
- R10: A load response returns the current word at the request address. A store response returns the stored data.
- R11: After reset every line is invalid, `cpu_req_ready` is 1, and `cpu_rsp_valid` and `mem_req_valid` are 0.
- R12: With 2 sets of lines, an empty cache, and loads to blocks 0, 8, 0, 6, 8 in that order, the responses are miss, miss, hit, miss, miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req_valid | input | 1 | Processor request valid |
| cpu_req_ready | output | 1 | Cache can accept a request (idle) |
| cpu_req_we | input | 1 | 1 = store, 0 = load |
| cpu_req_addr | input | ADDR_W | Word address |
| cpu_req_wdata | input | DATA_W | Store data |
| cpu_rsp_valid | output | 1 | One-cycle response pulse |
| cpu_rsp_hit | output | 1 | 1 if the request hit on first lookup |
| cpu_rsp_rdata | output | DATA_W | Load data, or echoed store data |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_we | output | 1 | 1 = writeback word, 0 = refill read |
| mem_req_addr | output | ADDR_W | Memory word address |
| mem_req_wdata | output | DATA_W | Writeback data |
| mem_rsp_valid | input | 1 | Read data beat valid |
| mem_rsp_rdata | input | DATA_W | Read data |

## Verification
The bench keeps the default build: 8-bit word addresses, 16-bit data, 2-word lines and 2 sets. With only four lines in total, blocks that share a set collide after a few accesses. This makes the fixed five-block replacement sequence fit exactly, and a long pseudo-random run over 16 blocks reaches dirty evictions, clean evictions and write-allocate misses many times. In the later phases, memory ready is withheld in a periodic pattern. This exercises the stall and hold rules on both the writeback path and the refill path.

// File: rtl/cache2w_pkg.sv
package cache2w_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOK,
    ST_EVICT,
    ST_FETCH,
    ST_WAIT
  } seq_e;
endpackage

// File: rtl/cache2w_way.sv
module cache2w_way #(
  parameter int SETS   = 2,
  parameter int WORDS  = 2,
  parameter int TAG_W  = 6,
  parameter int DATA_W = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [$clog2(SETS)-1:0]      idx,
  input  logic [$clog2(WORDS)-1:0]     rd_off,
  input  logic [TAG_W-1:0]             cmp_tag,
  output logic                         hit,
  output logic                         vld,
  output logic                         drt,
  output logic [TAG_W-1:0]             tag_o,
  output logic [DATA_W-1:0]            word_o,
  input  logic                         wr_en,
  input  logic [$clog2(WORDS)-1:0]     wr_off,
  input  logic [DATA_W-1:0]            wr_data,
  input  logic                         dirty_set,
  input  logic                         install
);
  localparam int IDX_W = $clog2(SETS);
  localparam int OFF_W = $clog2(WORDS);
  localparam int LINES = SETS * WORDS;

  logic [SETS-1:0]   vld_q;
  logic [SETS-1:0]   drt_q;
  logic [TAG_W-1:0]  tag_q [SETS];
  logic [DATA_W-1:0] dat_q [LINES];

  // state bits: install clears dirty, a store hit sets it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      drt_q <= '0;
    end else begin
      if (install) begin
        vld_q[idx] <= 1'b1;
        drt_q[idx] <= 1'b0;
      end
      if (dirty_set) drt_q[idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (install) tag_q[idx] <= cmp_tag;
  end

  always_ff @(posedge clk) begin
    if (wr_en) dat_q[{idx, wr_off}] <= wr_data;
  end

  logic [IDX_W+OFF_W-1:0] rd_ptr;
  assign rd_ptr = {idx, rd_off};

  assign vld    = vld_q[idx];
  assign drt    = drt_q[idx];
  assign tag_o  = tag_q[idx];
  assign hit    = vld_q[idx] && (tag_q[idx] == cmp_tag);
  assign word_o = dat_q[rd_ptr];
endmodule

// File: rtl/cache2w_lru.sv
module cache2w_lru #(
  parameter int SETS = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [$clog2(SETS)-1:0] idx,
  input  logic                    touch,
  input  logic                    touch_way,
  input  logic                    vld0,
  input  logic                    vld1,
  output logic                    victim
);
  // one bit per set: the way used most recently
  logic [SETS-1:0] mru_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mru_q <= '0;
    else if (touch) mru_q[idx] <= touch_way;
  end

  // empty way first, then the older of two valid ways
  always_comb begin
    if (!vld0)      victim = 1'b0;
    else if (!vld1) victim = 1'b1;
    else            victim = ~mru_q[idx];
  end
endmodule

// File: rtl/cache2w_ctrl.sv
module cache2w_ctrl #(
  parameter int WORDS = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cpu_req_valid,
  output logic                        cpu_req_ready,
  input  logic                        any_hit,
  input  logic                        vic_way,
  input  logic                        vic_dirty,
  input  logic                        mem_req_ready,
  input  logic                        mem_rsp_valid,
  output cache2w_pkg::seq_e           state,
  output logic [$clog2(WORDS)-1:0]    cnt,
  output logic                        vic_q,
  output logic                        missed
);
  import cache2w_pkg::*;
  localparam int OFF_W = $clog2(WORDS);
  localparam logic [OFF_W-1:0] LAST = OFF_W'(WORDS - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      vic_q  <= 1'b0;
      missed <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (cpu_req_valid) begin
            state  <= ST_LOOK;
            missed <= 1'b0;
          end
        end
        ST_LOOK: begin
          if (any_hit) begin
            state <= ST_IDLE;
          end else begin
            missed <= 1'b1;
            vic_q  <= vic_way;
            cnt    <= '0;
            state  <= vic_dirty ? ST_EVICT : ST_FETCH;
          end
        end
        ST_EVICT: begin
          if (mem_req_ready) begin
            cnt <= cnt + 1'b1;
            if (cnt == LAST) state <= ST_FETCH;
          end
        end
        ST_FETCH: begin
          if (mem_req_ready) state <= ST_WAIT;
        end
        ST_WAIT: begin
          if (mem_rsp_valid) begin
            cnt   <= cnt + 1'b1;
            state <= (cnt == LAST) ? ST_LOOK : ST_FETCH;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign cpu_req_ready = (state == ST_IDLE);
endmodule

// File: rtl/cache2w.sv
module cache2w #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int WORDS  = 2,
  parameter int SETS   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  output logic              cpu_req_ready,
  input  logic              cpu_req_we,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [DATA_W-1:0] cpu_req_wdata,
  output logic              cpu_rsp_valid,
  output logic              cpu_rsp_hit,
  output logic [DATA_W-1:0] cpu_rsp_rdata,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_we,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [DATA_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_rdata
);
  import cache2w_pkg::*;
  localparam int IDX_W = $clog2(SETS);
  localparam int OFF_W = $clog2(WORDS);
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W;
  localparam int NWAY  = 2;

  // latched request
  logic              rq_we;
  logic [ADDR_W-1:0] rq_addr;
  logic [DATA_W-1:0] rq_wdata;
  logic [OFF_W-1:0]  rq_off;
  logic [IDX_W-1:0]  rq_idx;
  logic [TAG_W-1:0]  rq_tag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rq_we    <= 1'b0;
      rq_addr  <= '0;
      rq_wdata <= '0;
    end else if (cpu_req_valid && cpu_req_ready) begin
      rq_we    <= cpu_req_we;
      rq_addr  <= cpu_req_addr;
      rq_wdata <= cpu_req_wdata;
    end
  end

  assign rq_off = rq_addr[OFF_W-1:0];
  assign rq_idx = rq_addr[OFF_W +: IDX_W];
  assign rq_tag = rq_addr[ADDR_W-1 -: TAG_W];

  // sequencer
  seq_e             state;
  logic [OFF_W-1:0] cnt;
  logic             vic_q;
  logic             missed;
  logic             vic_way;
  logic             vic_dirty;
  logic             any_hit;
  logic             hit_way;

  // way arrays
  logic [NWAY-1:0]   hit_w;
  logic [NWAY-1:0]   vld_w;
  logic [NWAY-1:0]   drt_w;
  logic [NWAY-1:0]   wr_w;
  logic [NWAY-1:0]   dset_w;
  logic [NWAY-1:0]   inst_w;
  logic [TAG_W-1:0]  tag_w  [NWAY];
  logic [DATA_W-1:0] word_w [NWAY];

  logic             look;
  logic             fill_beat;
  logic             last_beat;
  logic             store_hit;
  logic [OFF_W-1:0] rd_off;
  logic [OFF_W-1:0] wr_off;
  logic [DATA_W-1:0] wr_data;

  assign look      = (state == ST_LOOK);
  assign any_hit   = |hit_w;
  assign hit_way   = hit_w[1];
  assign fill_beat = (state == ST_WAIT) && mem_rsp_valid;
  assign last_beat = (cnt == OFF_W'(WORDS - 1));
  assign store_hit = look && any_hit && rq_we;
  assign rd_off    = (state == ST_EVICT) ? cnt : rq_off;
  assign wr_off    = look ? rq_off : cnt;
  assign wr_data   = look ? rq_wdata : mem_rsp_rdata;

  cache2w_ctrl #(.WORDS(WORDS)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .cpu_req_valid (cpu_req_valid),
    .cpu_req_ready (cpu_req_ready),
    .any_hit       (any_hit),
    .vic_way       (vic_way),
    .vic_dirty     (vic_dirty),
    .mem_req_ready (mem_req_ready),
    .mem_rsp_valid (mem_rsp_valid),
    .state         (state),
    .cnt           (cnt),
    .vic_q         (vic_q),
    .missed        (missed)
  );

  for (genvar w = 0; w < NWAY; w++) begin : g_way
    localparam logic SEL = (w == 1);
    assign dset_w[w] = store_hit && (hit_way == SEL);
    assign wr_w[w]   = dset_w[w] || (fill_beat && (vic_q == SEL));
    assign inst_w[w] = fill_beat && last_beat && (vic_q == SEL);

    cache2w_way #(
      .SETS   (SETS),
      .WORDS  (WORDS),
      .TAG_W  (TAG_W),
      .DATA_W (DATA_W)
    ) u_way (
      .clk       (clk),
      .rst_n     (rst_n),
      .idx       (rq_idx),
      .rd_off    (rd_off),
      .cmp_tag   (rq_tag),
      .hit       (hit_w[w]),
      .vld       (vld_w[w]),
      .drt       (drt_w[w]),
      .tag_o     (tag_w[w]),
      .word_o    (word_w[w]),
      .wr_en     (wr_w[w]),
      .wr_off    (wr_off),
      .wr_data   (wr_data),
      .dirty_set (dset_w[w]),
      .install   (inst_w[w])
    );
  end

  // recency: hits and completed fills both count as a use
  logic touch;
  logic touch_way;
  assign touch     = (look && any_hit) || (|inst_w);
  assign touch_way = look ? hit_way : vic_q;

  cache2w_lru #(.SETS(SETS)) u_lru (
    .clk       (clk),
    .rst_n     (rst_n),
    .idx       (rq_idx),
    .touch     (touch),
    .touch_way (touch_way),
    .vld0      (vld_w[0]),
    .vld1      (vld_w[1]),
    .victim    (vic_way)
  );

  assign vic_dirty = vld_w[vic_way] && drt_w[vic_way];

  // memory request channel
  assign mem_req_valid = (state == ST_EVICT) || (state == ST_FETCH);
  assign mem_req_we    = (state == ST_EVICT);
  assign mem_req_addr  = (state == ST_EVICT) ? {tag_w[vic_q], rq_idx, cnt}
                                             : {rq_tag, rq_idx, cnt};
  assign mem_req_wdata = word_w[vic_q];

  // processor response, one-cycle pulse
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_rsp_valid <= 1'b0;
      cpu_rsp_hit   <= 1'b0;
      cpu_rsp_rdata <= '0;
    end else begin
      cpu_rsp_valid <= look && any_hit;
      if (look && any_hit) begin
        cpu_rsp_hit   <= !missed;
        cpu_rsp_rdata <= rq_we ? rq_wdata : word_w[hit_way];
      end
    end
  end
endmodule

// File: rtl/cache2w_chk.sv
module cache2w_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_req_valid,
  input logic              cpu_req_ready,
  input logic              cpu_rsp_valid,
  input logic              cpu_rsp_hit,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic              mem_req_we,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic [DATA_W-1:0] mem_req_wdata,
  input logic [1:0]        hit_w
);
  logic traffic_q;
  logic read_seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      traffic_q   <= 1'b0;
      read_seen_q <= 1'b0;
    end else begin
      if (cpu_req_valid && cpu_req_ready) traffic_q <= 1'b0;
      else if (mem_req_valid && mem_req_ready) traffic_q <= 1'b1;
      if (cpu_rsp_valid) read_seen_q <= 1'b0;
      else if (mem_req_valid && mem_req_ready && !mem_req_we) read_seen_q <= 1'b1;
    end
  end

  AST_ONE_WAY_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_w)) else $error("two ways hit"); // R1

  AST_HIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rsp_valid && cpu_rsp_hit |-> !traffic_q) else $error("hit used memory"); // R4

  AST_MISS_FETCHED: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rsp_valid && !cpu_rsp_hit |-> traffic_q) else $error("miss without refill"); // R7

  AST_EVICT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    !(read_seen_q && mem_req_valid && mem_req_we)) else $error("write after refill read"); // R5

  AST_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !cpu_req_ready) else $error("ready during miss"); // R8

  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rsp_valid |=> !cpu_rsp_valid) else $error("response longer than a cycle"); // R8

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_we)
      && $stable(mem_req_addr) && $stable(mem_req_wdata)) else $error("request dropped"); // R9
endmodule

bind cache2w cache2w_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cpu_req_valid (cpu_req_valid),
  .cpu_req_ready (cpu_req_ready),
  .cpu_rsp_valid (cpu_rsp_valid),
  .cpu_rsp_hit   (cpu_rsp_hit),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_we    (mem_req_we),
  .mem_req_addr  (mem_req_addr),
  .mem_req_wdata (mem_req_wdata),
  .hit_w         (hit_w)
);

// File: tb/cache2w_bench.sv
module cache2w_bench;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int WD = 2;
  localparam int NS = 2;
  localparam int MW = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic          cpu_req_valid, cpu_req_ready, cpu_req_we;
  logic [AW-1:0] cpu_req_addr;
  logic [DW-1:0] cpu_req_wdata;
  logic          cpu_rsp_valid, cpu_rsp_hit;
  logic [DW-1:0] cpu_rsp_rdata;
  logic          mem_req_valid, mem_req_ready, mem_req_we;
  logic [AW-1:0] mem_req_addr;
  logic [DW-1:0] mem_req_wdata;
  logic          mem_rsp_valid;
  logic [DW-1:0] mem_rsp_rdata;

  cache2w #(.ADDR_W(AW), .DATA_W(DW), .WORDS(WD), .SETS(NS)) u_cache2w (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
    .cpu_req_we(cpu_req_we), .cpu_req_addr(cpu_req_addr), .cpu_req_wdata(cpu_req_wdata),
    .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_hit(cpu_rsp_hit), .cpu_rsp_rdata(cpu_rsp_rdata),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_we(mem_req_we),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata)
  );

  int total = 0;
  int bad = 0;

  task automatic check(input bit ok, input string rq, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // behavioural reference: cache contents, recency, golden memory, expected traffic
  bit mv [NS][2];
  bit md [NS][2];
  int mt [NS][2];
  int mdat [NS][2][WD];
  int mru [NS];
  int gmem [MW];
  int smem [MW];
  int q_we [$];
  int q_addr [$];
  int q_dat [$];

  task automatic model(input bit we, input int addr, input int wd, output bit eh, output int ed);
    int idx, tg, off, w, a;
    off = addr % WD;
    idx = (addr / WD) % NS;
    tg  = addr / (WD * NS);
    w = -1;
    for (int k = 0; k < 2; k++) if (mv[idx][k] && mt[idx][k] == tg) w = k;
    eh = (w >= 0);
    if (!eh) begin
      if (!mv[idx][0]) w = 0;
      else if (!mv[idx][1]) w = 1;
      else w = 1 - mru[idx];
      if (mv[idx][w] && md[idx][w]) begin
        for (int o = 0; o < WD; o++) begin
          a = (mt[idx][w] * NS + idx) * WD + o;
          q_we.push_back(1); q_addr.push_back(a); q_dat.push_back(mdat[idx][w][o]);
          gmem[a] = mdat[idx][w][o];
        end
      end
      for (int o = 0; o < WD; o++) begin
        a = (tg * NS + idx) * WD + o;
        q_we.push_back(0); q_addr.push_back(a); q_dat.push_back(0);
        mdat[idx][w][o] = gmem[a];
      end
      mv[idx][w] = 1; md[idx][w] = 0; mt[idx][w] = tg;
    end
    mru[idx] = w;
    if (we) begin
      mdat[idx][w][off] = wd; md[idx][w] = 1; ed = wd;
    end else ed = mdat[idx][w][off];
  endtask

  // memory side and per-clock observation
  int cyc = 0;
  int wr_count = 0;
  int rd_count = 0;
  int stall_err = 0;
  bit bp_en = 0;
  bit outstanding = 0;
  bit prev_rsp = 0;
  bit rd_pend = 0;
  int rd_addr = 0;
  bit held = 0;
  int held_addr = 0;
  bit held_we = 0;

  initial begin
    mem_req_ready = 1'b0;
    mem_rsp_valid = 1'b0;
    mem_rsp_rdata = '0;
    for (int a = 0; a < MW; a++) begin
      smem[a] = (a * 291 + 23040) & 16'hFFFF;
      gmem[a] = smem[a];
    end
    forever begin
      @(negedge clk);
      cyc++;
      mem_rsp_valid = 1'b0;
      if (rd_pend) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_rdata = DW'(smem[rd_addr]);
        rd_pend = 0;
      end
      if (rst_n && held) begin
        check(mem_req_valid && mem_req_addr == AW'(held_addr) && mem_req_we == held_we,
              "R9", "request held", int'(mem_req_addr), held_addr);
      end
      mem_req_ready = bp_en ? ((cyc % 3) != 1) : 1'b1;
      held = rst_n && mem_req_valid && !mem_req_ready;
      held_addr = int'(mem_req_addr);
      held_we = mem_req_we;
      if (rst_n && mem_req_valid && mem_req_ready) begin
        if (q_we.size() == 0) begin
          check(0, "R6", "unexpected memory access", int'(mem_req_addr), 0);
        end else begin
          int ew, ea, ed;
          ew = q_we.pop_front(); ea = q_addr.pop_front(); ed = q_dat.pop_front();
          check(int'(mem_req_we) == ew, "R5", "access kind", int'(mem_req_we), ew);
          check(int'(mem_req_addr) == ea, ew ? "R5" : "R3", "access address", int'(mem_req_addr), ea);
          if (ew == 1) check(int'(mem_req_wdata) == ed, "R5", "writeback data", int'(mem_req_wdata), ed);
        end
        if (mem_req_we) begin
          smem[int'(mem_req_addr)] = int'(mem_req_wdata);
          wr_count++;
        end else begin
          rd_pend = 1;
          rd_addr = int'(mem_req_addr);
          rd_count++;
        end
      end
      if (rst_n && cpu_rsp_valid && prev_rsp) check(0, "R8", "response pulse width", 2, 1);
      prev_rsp = cpu_rsp_valid;
      if (outstanding && cpu_req_ready && !cpu_rsp_valid) stall_err++;
      if (cyc > 150000) begin
        check(0, "WD", "watchdog expired", cyc, 150000);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  task automatic access(input bit we, input int addr, input int wd, input string rq, output bit got);
    bit eh;
    int ed;
    model(we, addr, wd, eh, ed);
    @(negedge clk);
    cpu_req_valid = 1'b1;
    cpu_req_we    = we;
    cpu_req_addr  = AW'(addr);
    cpu_req_wdata = DW'(wd);
    while (!cpu_req_ready) @(negedge clk);
    @(negedge clk);
    cpu_req_valid = 1'b0;
    outstanding = 1;
    stall_err = 0;
    while (!cpu_rsp_valid) @(negedge clk);
    outstanding = 0;
    check(cpu_rsp_hit == eh, rq, "hit flag", int'(cpu_rsp_hit), int'(eh));
    check(cpu_rsp_rdata == DW'(ed), "R10", "response data", int'(cpu_rsp_rdata), ed & 16'hFFFF);
    check(q_we.size() == 0, "R5", "memory traffic left over", q_we.size(), 0);
    check(stall_err == 0, "R8", "ready while stalled", stall_err, 0);
    got = cpu_rsp_hit;
  endtask

  initial begin
    bit h;
    int w0, r0;
    bit [31:0] lf;
    int seq [5];
    bit exp_h [5];
    cpu_req_valid = 1'b0;
    cpu_req_we    = 1'b0;
    cpu_req_addr  = '0;
    cpu_req_wdata = '0;
    repeat (3) @(negedge clk);
    // R11: reset state
    check(cpu_req_ready == 1'b1, "R11", "ready in reset", int'(cpu_req_ready), 1);
    check(cpu_rsp_valid == 1'b0, "R11", "rsp in reset", int'(cpu_rsp_valid), 0);
    check(mem_req_valid == 1'b0, "R11", "mem req in reset", int'(mem_req_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(cpu_req_ready == 1'b1 && mem_req_valid == 1'b0, "R11", "idle after reset",
          int'(cpu_req_ready), 1);

    // R12: blocks 0,8,0,6,8 into one set
    seq = '{0, 8, 0, 6, 8};
    exp_h = '{0, 0, 1, 0, 0};
    for (int i = 0; i < 5; i++) begin
      access(0, seq[i] * WD, 0, "R3", h);
      check(h == exp_h[i], "R12", "sequence hit/miss", int'(h), int'(exp_h[i]));
    end

    // R4: store hit on block 8, no memory write
    w0 = wr_count; r0 = rd_count;
    access(1, 17, 16'hBEEF, "R4", h);
    check(h == 1 && wr_count == w0 && rd_count == r0, "R4", "store hit traffic",
          wr_count - w0 + rd_count - r0, 0);
    access(0, 17, 0, "R10", h);
    check(cpu_rsp_rdata == 16'hBEEF, "R10", "load after store", int'(cpu_rsp_rdata), 16'hBEEF);

    // R6: clean victim (block 6) replaced by block 0
    w0 = wr_count;
    access(0, 0, 0, "R3", h);
    check(wr_count == w0, "R6", "clean eviction writes", wr_count - w0, 0);

    // R5: dirty victim (block 8) evicted by block 6
    w0 = wr_count; r0 = rd_count;
    access(0, 12, 0, "R3", h);
    check(wr_count - w0 == WD && rd_count - r0 == WD, "R5", "dirty eviction beats",
          wr_count - w0, WD);

    // R7 and R2: store miss into empty set, then second block
    r0 = rd_count;
    access(1, 2, 16'h1234, "R7", h);
    check(h == 0 && rd_count - r0 == WD, "R7", "write allocate refill", rd_count - r0, WD);
    access(0, 2, 0, "R7", h);
    check(h == 1 && cpu_rsp_rdata == 16'h1234, "R7", "allocated store kept",
          int'(cpu_rsp_rdata), 16'h1234);
    access(0, 6, 0, "R2", h);
    access(0, 3, 0, "R2", h);
    check(h == 1, "R2", "first block still resident", int'(h), 1);
    access(0, 7, 0, "R2", h);
    check(h == 1, "R2", "second block resident", int'(h), 1);

    // R1 and R3: pseudo-random mix under memory back-pressure (R9)
    bp_en = 1;
    lf = 32'h1ACE_B00C;
    for (int n = 0; n < 300; n++) begin
      lf = lf * 32'd1103515245 + 32'd12345;
      access(lf[20:18] < 3, int'(lf[27:23]), int'(lf[15:0]) ^ n, "R1", h);
    end
    bp_en = 0;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule